// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block is an I/O-port slave for a host bridge. It provides configuration access through two port groups. An address port is a 32-bit register that holds a configuration target: an enable flag, a bus number, a device/function number and a register number of up to twelve bits. A data window is four bytes wide. When the enable flag is set, every read or write to the data window becomes one configuration request on a downstream request/response interface. That request carries the latched bus, device/function and dword index, plus byte enables that the block derives from the access size and the byte offset inside the window.

Software first writes the full 32-bit target to the address port. It then moves 8-, 16- or 32-bit quantities through the data window. Data on the I/O side is right-justified. The block moves it onto the correct byte lanes of the downstream dword, and back again for reads. A data-window read holds the I/O handshake until the downstream response returns. A write completes as soon as the downstream side accepts the request. When the enable flag is clear, the data window answers reads with all ones and drops writes.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address port is the four bytes at I/O address 0xCF8..0xCFB and the data window is 0xCFC..0xCFF. An access to any other address completes at once, returns 0xFFFFFFFF on a read, and has no effect.
- R2: A 32-bit write (io_size 2 or 3) to exactly 0xCF8 latches the target. Bit 31 is the enable flag, bits 27:24 are register bits 11:8, bits 23:16 are the bus, bits 15:8 are the device/function, and bits 7:2 are register bits 7:2. Bits 30:28 and 1:0 read back as zero, so writing 0x80000000 reads back exactly 0x80000000.
- R3: An 8- or 16-bit write anywhere in the address port leaves the latched target unchanged, including a byte write of 0x01 to 0xCFB. A narrow read of the address port returns the selected bytes, right-justified.
- R4: After reset the address register reads 0x00000000.
- R5: While the enable flag is clear, a data-window read returns 0xFFFFFFFF, a data-window write is dropped, and no downstream request is issued.
- R6: While the enable flag is set, each data-window access issues exactly one downstream request. It carries the latched bus and device/function, the dword index {register bits 11:8, register bits 7:2}, and dn_write equal to io_wr.
- R7: io_size encodes 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. The lane offset is io_addr[1:0] for a byte, {io_addr[1],0} for 16 bits, and 0 for 32 bits. dn_be is the size mask (0001, 0011 or 1111) shifted left by that offset.
- R8: Write data bits are placed on the downstream dword starting at byte lane offset. Read data is the response dword shifted right by offset bytes, with the bytes above the access size cleared.
- R9: An enabled data-window read keeps io_ready low until dn_rvalid arrives. An enabled write completes in the cycle dn_ready accepts it. A request with dn_ready low holds its fields stable.
- R10: Register number 4095 is reachable: it gives dword index 1023, so each function has 4096 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O access present, held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O port address |
| io_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | Access completes this cycle |
| io_rdata | output | 32 | Right-justified read data, valid with io_ready on a read |
| dn_valid | output | 1 | Downstream configuration request |
| dn_ready | input | 1 | Downstream accepts request |
| dn_write | output | 1 | Request is a write |
| dn_bus | output | 8 | Target bus |
| dn_devfn | output | 8 | Target device/function |
| dn_dreg | output | 10 | Target dword index |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-steered write data |
| dn_rvalid | input | 1 | Read response valid |
| dn_rdata | input | 32 | Read response dword |

## Verification
The checks that run every cycle cover these properties:
- No request is issued while the enable flag is clear.
- Byte enables always form a 1-, 2- or 4-bit pattern.
- A request that is not yet accepted holds its fields.
- An enabled read never completes without a response.
- The target changes only on a full-width write to 0xCF8, and then takes the masked value.

Only the bench scenarios can show the rest. These are the lane placement of data in both directions against a configuration-space model, the merge of partial writes, all-ones reads and dropped writes when disabled, ignored narrow address writes, and reach to register 4095.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int REG_W  = 12;
  localparam int DREG_W = REG_W - 2;
  localparam logic [31:0] ADDR_KEEP = 32'h8FFF_FFFC;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} seq_st_e;

  typedef struct packed {
    logic       en;
    logic [3:0] reg_hi;
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [5:0] reg_lo;
  } cfg_addr_t;

  function automatic logic [3:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] lane_of(logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'd0:    return off;
      2'd1:    return {off[1], 1'b0};
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] be_of(logic [1:0] sz, logic [1:0] off);
    return size_mask(sz) << lane_of(sz, off);
  endfunction

  function automatic logic [31:0] lanes_in(logic [31:0] d, logic [1:0] lane);
    return d << {lane, 3'b000};
  endfunction

  function automatic logic [31:0] lanes_out(logic [31:0] d, logic [1:0] sz, logic [1:0] lane);
    logic [31:0] s;
    s = d >> {lane, 3'b000};
    case (sz)
      2'd0:    return {24'h0, s[7:0]};
      2'd1:    return {16'h0, s[15:0]};
      default: return s;
    endcase
  endfunction

  function automatic cfg_addr_t unpack_addr(logic [31:0] w);
    cfg_addr_t a;
    a.en     = w[31];
    a.reg_hi = w[27:24];
    a.bus    = w[23:16];
    a.devfn  = w[15:8];
    a.reg_lo = w[7:2];
    return a;
  endfunction

  function automatic logic [31:0] pack_addr(cfg_addr_t a);
    return {a.en, 3'b000, a.reg_hi, a.bus, a.devfn, a.reg_lo, 2'b00};
  endfunction
endpackage

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] wdata,
  output cfg_addr_t   cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cur <= '0;
    else if (load)  cur <= unpack_addr(wdata);
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pack_addr(cur) == ($past(wdata) & ADDR_KEEP)); // R2
endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
)(
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  output logic             hit_aport,
  output logic             aport_exact,
  output logic             hit_win,
  output logic [1:0]       lane,
  output logic [3:0]       be
);
  localparam int HI = IO_AW - 1;

  assign hit_aport   = (io_addr[HI:2] == ADDR_PORT[HI:2]);
  assign aport_exact = (io_addr == ADDR_PORT);
  assign hit_win     = (io_addr[HI:2] == DATA_PORT[HI:2]);
  assign lane        = lane_of(io_size, io_addr[1:0]);
  assign be          = be_of(io_size, io_addr[1:0]);
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_wr,
  input  logic dn_ready,
  input  logic dn_rvalid,
  output logic idle,
  output logic dn_valid,
  output logic wr_done,
  output logic rd_done
);
  seq_st_e st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (start)     nxt = ST_REQ;
      ST_REQ:  if (dn_ready)  nxt = is_wr ? ST_IDLE : ST_RSP;
      ST_RSP:  if (dn_rvalid) nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign idle     = (st == ST_IDLE);
  assign dn_valid = (st == ST_REQ);
  assign wr_done  = (st == ST_REQ) && dn_ready && is_wr;
  assign rd_done  = (st == ST_RSP) && dn_rvalid;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> dn_valid); // R9
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgp_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [1:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              io_ready,
  output logic [31:0]       io_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [7:0]        dn_bus,
  output logic [7:0]        dn_devfn,
  output logic [DREG_W-1:0] dn_dreg,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  input  logic              dn_rvalid,
  input  logic [31:0]       dn_rdata
);
  logic      hit_aport, aport_exact, hit_win;
  logic [1:0] lane;
  logic [3:0] be;
  cfg_addr_t  cur;
  logic       load_evt, start_evt, quick_evt;
  logic       idle, wr_done, rd_done;

  cfgp_decode #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .io_addr(io_addr), .io_size(io_size), .hit_aport(hit_aport),
    .aport_exact(aport_exact), .hit_win(hit_win), .lane(lane), .be(be)
  );

  assign load_evt  = io_valid && io_wr && aport_exact && io_size[1];
  assign start_evt = idle && io_valid && hit_win && cur.en;
  assign quick_evt = idle && io_valid && !(hit_win && cur.en);

  cfgp_addr_latch u_addr (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .wdata(io_wdata), .cur(cur)
  );

  cfgp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .is_wr(io_wr),
    .dn_ready(dn_ready), .dn_rvalid(dn_rvalid), .idle(idle),
    .dn_valid(dn_valid), .wr_done(wr_done), .rd_done(rd_done)
  );

  assign io_ready = quick_evt || wr_done || rd_done;

  always_comb begin
    if (rd_done)        io_rdata = lanes_out(dn_rdata, io_size, lane);
    else if (hit_aport) io_rdata = lanes_out(pack_addr(cur), io_size, lane);
    else                io_rdata = '1;
  end

  assign dn_write = io_wr;
  assign dn_bus   = cur.bus;
  assign dn_devfn = cur.devfn;
  assign dn_dreg  = {cur.reg_hi, cur.reg_lo};
  assign dn_be    = be;
  assign dn_wdata = lanes_in(io_wdata, lane);

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> cur.en); // R5
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ($countones(dn_be) == 1 || $countones(dn_be) == 2 || $countones(dn_be) == 4)); // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> ($stable(dn_be) && $stable(dn_wdata) && $stable(dn_dreg) && $stable(dn_write))); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(cur)); // R3
  AST_RD_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_ready && !io_wr && hit_win && cur.en) |-> dn_rvalid); // R9
  AST_OFF_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_ready && !io_wr && hit_win && !cur.en) |-> (io_rdata == 32'hFFFF_FFFF)); // R5
endmodule

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        io_valid = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [1:0]  io_size = 0;
  logic [31:0] io_wdata = 0;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        dn_valid, dn_write;
  logic        dn_ready = 0, dn_rvalid = 0;
  logic [31:0] dn_rdata = 0;
  logic [7:0]  dn_bus, dn_devfn;
  logic [9:0]  dn_dreg;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata;

  cfg_port_bridge uut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_wr(io_wr), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_ready(io_ready), .io_rdata(io_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write), .dn_bus(dn_bus),
    .dn_devfn(dn_devfn), .dn_dreg(dn_dreg), .dn_be(dn_be), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configuration-space model
  logic [31:0] mem [64];
  int          req_cnt = 0;
  logic [7:0]  l_bus, l_devfn;
  logic [9:0]  l_dreg;
  logic [3:0]  l_be;
  logic        l_wr;
  bit          pend = 0;
  int          pend_dly = 0;
  logic [5:0]  pidx;

  function automatic logic [5:0] midx(logic [7:0] b, logic [7:0] df, logic [9:0] dr);
    return {b[1:0], df[1:0], dr[1:0]};
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = 32'h9E37_79B9 * (i + 3);

  always @(posedge clk) begin
    if (rst_n && dn_valid && dn_ready) begin
      req_cnt++;
      l_bus = dn_bus; l_devfn = dn_devfn; l_dreg = dn_dreg; l_be = dn_be; l_wr = dn_write;
      if (dn_write) begin
        for (int k = 0; k < 4; k++)
          if (dn_be[k]) mem[midx(dn_bus, dn_devfn, dn_dreg)][8*k +: 8] = dn_wdata[8*k +: 8];
      end else begin
        pend = 1; pidx = midx(dn_bus, dn_devfn, dn_dreg); pend_dly = $urandom % 3;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      dn_ready  = ($urandom % 2) == 1;
      dn_rvalid = 0;
      if (pend) begin
        if (pend_dly == 0) begin dn_rvalid = 1; dn_rdata = mem[pidx]; pend = 0; end
        else pend_dly--;
      end
    end
  end

  // bench-side arithmetic
  function automatic logic [31:0] e_addr(logic [31:0] w);
    return {w[31], 3'b000, w[27:2], 2'b00};
  endfunction
  function automatic int e_off(logic [1:0] sz, logic [1:0] a);
    if (sz == 0) return a;
    if (sz == 1) return a[1] ? 2 : 0;
    return 0;
  endfunction
  function automatic int e_nbytes(logic [1:0] sz);
    return sz == 0 ? 1 : (sz == 1 ? 2 : 4);
  endfunction
  function automatic logic [3:0] e_be(logic [1:0] sz, logic [1:0] a);
    logic [3:0] r = 0;
    for (int k = 0; k < 4; k++)
      if (k >= e_off(sz, a) && k < e_off(sz, a) + e_nbytes(sz)) r[k] = 1;
    return r;
  endfunction
  function automatic logic [31:0] e_read(logic [31:0] w, logic [1:0] sz, logic [1:0] a);
    logic [31:0] r = 0;
    for (int k = 0; k < e_nbytes(sz); k++) r[8*k +: 8] = w[8*(k + e_off(sz, a)) +: 8];
    return r;
  endfunction
  function automatic logic [31:0] e_merge(logic [31:0] old, logic [31:0] wd, logic [1:0] sz, logic [1:0] a);
    logic [31:0] r = old;
    for (int k = 0; k < e_nbytes(sz); k++) r[8*(k + e_off(sz, a)) +: 8] = wd[8*k +: 8];
    return r;
  endfunction

  logic [31:0] rd;
  int          cyc;

  task automatic io_op(bit wr, logic [15:0] a, logic [1:0] sz, logic [31:0] wd);
    @(negedge clk);
    io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd; io_valid = 1;
    cyc = 0;
    forever begin
      #1;
      if (io_ready) begin
        rd = io_rdata;
        @(posedge clk);
        break;
      end
      cyc++;
      @(negedge clk);
    end
    #1 io_valid = 0;
  endtask

  logic [31:0] sh;

  task automatic set_addr(logic [31:0] w);
    io_op(1, 16'hCF8, 2, w);
    sh = e_addr(w);
  endtask

  task automatic win_op(bit wr, logic [1:0] off, logic [1:0] sz, logic [31:0] wd, string req);
    logic [5:0]  ix;
    logic [31:0] pre;
    int          rc;
    ix  = midx(sh[23:16], sh[15:8], {sh[27:24], sh[7:2]});
    pre = mem[ix];
    rc  = req_cnt;
    io_op(wr, 16'hCFC + 16'(off), sz, wd);
    if (!sh[31]) begin
      chk(req_cnt == rc, {req, " R5 no request"}, req_cnt, rc);
      if (wr) chk(mem[ix] == pre, {req, " R5 write dropped"}, mem[ix], pre);
      else    chk(rd == 32'hFFFF_FFFF, {req, " R5 ones"}, rd, 32'hFFFF_FFFF);
    end else begin
      chk(req_cnt == rc + 1, {req, " R6 one request"}, req_cnt, rc + 1);
      chk({l_bus, l_devfn, 6'h0, l_dreg} == {sh[23:16], sh[15:8], 6'h0, sh[27:24], sh[7:2]},
          {req, " R6 target"}, {l_bus, l_devfn, 6'h0, l_dreg}, {sh[23:16], sh[15:8], 6'h0, sh[27:24], sh[7:2]});
      chk(l_be == e_be(sz, off) && l_wr == wr, {req, " R7 be"}, {27'h0, l_wr, l_be}, {27'h0, wr, e_be(sz, off)});
      if (wr) chk(mem[ix] == e_merge(pre, wd, sz, off), {req, " R8 write lanes"}, mem[ix], e_merge(pre, wd, sz, off));
      else begin
        chk(rd == e_read(pre, sz, off), {req, " R8 read lanes"}, rd, e_read(pre, sz, off));
        chk(cyc >= 2, {req, " R9 read stall"}, cyc, 2);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    io_op(0, 16'hCF8, 2, 0);
    chk(rd == 0, "R4 reset addr", rd, 0);
    sh = 0;

    set_addr(32'h8000_0000);
    io_op(0, 16'hCF8, 2, 0);
    chk(rd == 32'h8000_0000, "R2 readback 0x80000000", rd, 32'h8000_0000);
    set_addr(32'hFFFF_FFFF);
    io_op(0, 16'hCF8, 2, 0);
    chk(rd == 32'h8FFF_FFFC, "R2 reserved bits zero", rd, 32'h8FFF_FFFC);

    set_addr(32'h8012_3404);
    io_op(1, 16'hCFB, 0, 32'h01);
    io_op(0, 16'hCF8, 2, 0);
    chk(rd == 32'h8012_3404, "R3 byte write CFB ignored", rd, 32'h8012_3404);
    io_op(1, 16'hCF8, 1, 32'hBEEF);
    io_op(0, 16'hCF8, 2, 0);
    chk(rd == 32'h8012_3404, "R3 half write ignored", rd, 32'h8012_3404);
    io_op(0, 16'hCFB, 0, 0);
    chk(rd == 32'h80, "R3 byte read CFB", rd, 32'h80);
    io_op(0, 16'hCFA, 1, 0);
    chk(rd == 32'h8012, "R3 half read CFA", rd, 32'h8012);

    io_op(0, 16'hCF4, 2, 0);
    chk(rd == 32'hFFFF_FFFF, "R1 foreign read", rd, 32'hFFFF_FFFF);
    io_op(1, 16'hD00, 2, 32'h1234_5678);
    io_op(0, 16'hCF8, 2, 0);
    chk(rd == 32'h8012_3404, "R1 foreign write no effect", rd, 32'h8012_3404);

    set_addr(32'h0001_0200);
    win_op(0, 0, 2, 0, "disabled read");
    win_op(1, 1, 0, 32'hAA, "disabled write");

    set_addr(32'h8F00_00FC);
    win_op(1, 3, 0, 32'h5A, "R10 reg 4095 write");
    chk(l_dreg == 10'd1023, "R10 dword index", l_dreg, 1023);
    win_op(0, 3, 0, 0, "R10 reg 4095 read");

    set_addr(32'h8001_0208);
    win_op(1, 2, 1, 32'hFFFF_C0DE, "R8 half hi write");
    win_op(0, 2, 1, 0, "R8 half hi read");
    win_op(0, 3, 1, 0, "R7 half odd offset");
    win_op(0, 1, 2, 0, "R7 word odd offset");

    for (int n = 0; n < 400; n++) begin
      int pick = $urandom % 10;
      if (pick < 2) begin
        logic [31:0] w = $urandom;
        if (($urandom % 5) != 0) w[31] = 1'b1;
        set_addr(w);
      end else if (pick == 2) begin
        logic [1:0] o = 2'($urandom), s = 2'($urandom);
        io_op(0, 16'hCF8 + 16'(o), s, 0);
        chk(rd == e_read(sh, s, o), "R3 random addr read", rd, e_read(sh, s, o));
      end else begin
        win_op($urandom % 2, 2'($urandom), 2'($urandom), $urandom, "random window");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule